// File: doc/BRIEF.md
# DDR On-Die Termination Controller

This block sits beside a DDR memory controller's command scheduler and drives the pin that switches on the termination resistors inside the memory. It also produces the termination bit fields that the controller places into the memory's mode registers during initialisation. It accepts a memory-type select, a nominal termination code and a write-only (dynamic) termination code. It checks these against what each memory type supports. Codes that are illegal are flagged and are treated as termination off.

The scheduler raises a write, read or self-refresh request. When termination is in effect for writes, a write is held back until the termination pin has been high for a programmed lead time. The block then enables write data for one burst and keeps the termination pin high for one further burst length after the last beat. Reads and self-refresh entry cut that hold short. Without effective termination, writes start at once and the pin stays low.

The sequencer has five states:
- IDLE
- LEAD: the termination pin is up and the lead time is counting.
- BURST: write data is enabled.
- HOLD: the termination pin is up after the burst.
- SREF: self-refresh.

The transitions are:
- IDLE→SREF on a self-refresh request.
- IDLE→LEAD on a write with termination and a nonzero lead.
- IDLE→BURST on a write without lead.
- LEAD→BURST when the lead expires.
- BURST→BURST when a write is pending on the last beat.
- BURST→HOLD when the burst ends with termination.
- BURST→IDLE when the burst ends without termination.
- HOLD→SREF on a self-refresh request.
- HOLD→BURST on a write request.
- HOLD→IDLE on a read request or when the hold expires.
- SREF→IDLE on release.

Top module: `term_ctrl`

## Requirements
- R1: Memory type encoding is 1 = LPDDR, 2 = DDR2, 3 = DDR3; type 0 is reserved. For LPDDR and type 0 the termination pin `odt` never rises, and `mr1_rtt` and `mr2_rtt_wr` read 0.
- R2: For DDR2, nominal codes 1, 2 and 3 (75, 150 and 50 ohm) appear unchanged on `mr1_rtt`. The dynamic code is ignored: `mr2_rtt_wr` reads 0 and no error is raised for it.
- R3: For DDR3, nominal codes 1 to 5 (RZQ/4, RZQ/2, RZQ/6, RZQ/12, RZQ/8) appear unchanged on `mr1_rtt`. Dynamic codes 1 (RZQ/4) and 2 (RZQ/2) appear unchanged on `mr2_rtt_wr`.
- R4: The following raise `cfg_err` and drive the affected field to 0 (termination off):
  - reserved nominal codes: 4 to 7 for DDR2, 6 and 7 for DDR3, any nonzero code for LPDDR;
  - dynamic code 3 for DDR3;
  - type 0.

  The fields and `cfg_err` follow the configuration inputs one clock later.
- R5: With termination in effect and lead L = `lead_cyc` from 1 to 7, a sampled write request raises `odt` on the next cycle. `wdata_en` rises exactly L cycles after `odt`.
- R6: With termination in effect and L = 0, `odt` and `wdata_en` rise in the same cycle, one cycle after the request.
- R7: Each burst holds `wdata_en` high for BEATS cycles. `wr_start` is high only in the first beat of each burst.
- R8: After the last beat, `odt` stays high for BEATS cycles and then falls, unless a request intervenes.
- R9: A write request present on the last beat, or during the hold, starts the next burst on the following cycle with no new lead.
- R10: Request priority is as follows:
  - In IDLE and HOLD, self-refresh comes before a write, and a write comes before a read.
  - A read during HOLD drops `odt` on the next cycle.
  - Self-refresh drops `odt` and holds both `odt` and `wdata_en` low until released, ignoring writes.
- R11: When neither code is in effect, a write starts one cycle after the request with `odt` low throughout.
- R12: `odt`, `wdata_en` and `wr_start` are low in reset and whenever no write is leading, bursting or holding. With only the dynamic code in effect, termination appears only around writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_type | input | 2 | Memory type select |
| nom_code | input | 3 | Nominal termination code |
| dyn_code | input | 2 | Write-only termination code |
| lead_cyc | input | LEAD_W | Cycles from termination rise to first write beat |
| wr_req | input | 1 | Write pending from scheduler |
| rd_req | input | 1 | Read request from scheduler |
| sr_req | input | 1 | Self-refresh request (level) |
| odt | output | 1 | Memory termination enable pin |
| wdata_en | output | 1 | Write data driven this cycle |
| wr_start | output | 1 | First beat of a write burst |
| mr1_rtt | output | 3 | Nominal termination field for mode register 1 |
| mr2_rtt_wr | output | 2 | Write termination field for mode register 2 |
| cfg_err | output | 1 | Illegal code or type configured |

## Verification
The bench sweeps every combination of type, nominal code and dynamic code. A decoder that passes a reserved code through would drive a termination value the memory does not define, or would raise the pin with no legal setting behind it. Lead times from 0 to 7 are measured from the pin's rise to the first beat. An off-by-one counter would either drive data before the termination settles or waste a cycle per write. The bench also targets back-to-back bursts and writes, reads and self-refresh arriving during the hold. A design that re-ran the lead on those would leave gaps between bursts. A design that ignored the read or self-refresh would keep termination on while the memory drives or sleeps.

// File: rtl/term_pkg.sv
package term_pkg;
    localparam int TYPE_W = 2;
    localparam int NOM_W  = 3;
    localparam int DYN_W  = 2;

    typedef enum logic [TYPE_W-1:0] {
        MT_NONE = 2'd0,
        MT_LP   = 2'd1,
        MT_D2   = 2'd2,
        MT_D3   = 2'd3
    } mem_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BURST,
        ST_HOLD,
        ST_SREF
    } odt_state_t;

    // highest legal code per memory kind
    localparam logic [NOM_W-1:0] D2_NOM_MAX = NOM_W'(3);
    localparam logic [NOM_W-1:0] D3_NOM_MAX = NOM_W'(5);
    localparam logic [DYN_W-1:0] D3_DYN_MAX = DYN_W'(2);
endpackage

// File: rtl/term_decode.sv
module term_decode
    import term_pkg::*;
#(
    parameter int LEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TYPE_W-1:0] mem_type,
    input  logic [NOM_W-1:0]  nom_code,
    input  logic [DYN_W-1:0]  dyn_code,
    input  logic [LEAD_W-1:0] lead_cyc,
    output logic [NOM_W-1:0]  mr1_rtt,
    output logic [DYN_W-1:0]  mr2_rtt_wr,
    output logic              cfg_err,
    output logic              term_on,
    output logic [LEAD_W-1:0] lead_q
);
    logic nom_ok, nom_bad, dyn_ok, dyn_bad, type_bad;
    logic [NOM_W-1:0] nom_eff;
    logic [DYN_W-1:0] dyn_eff;

    always_comb begin
        nom_ok   = 1'b0;
        nom_bad  = 1'b0;
        dyn_ok   = 1'b0;
        dyn_bad  = 1'b0;
        type_bad = 1'b0;
        unique case (mem_kind_t'(mem_type))
            MT_NONE: type_bad = 1'b1;
            MT_LP: begin
                // no termination at all on this kind
                nom_bad = (nom_code != '0);
            end
            MT_D2: begin
                nom_ok  = (nom_code != '0) && (nom_code <= D2_NOM_MAX);
                nom_bad = (nom_code > D2_NOM_MAX);
            end
            MT_D3: begin
                nom_ok  = (nom_code != '0) && (nom_code <= D3_NOM_MAX);
                nom_bad = (nom_code > D3_NOM_MAX);
                dyn_ok  = (dyn_code != '0) && (dyn_code <= D3_DYN_MAX);
                dyn_bad = (dyn_code > D3_DYN_MAX);
            end
            default: type_bad = 1'b1;
        endcase
        nom_eff = nom_ok ? nom_code : '0;
        dyn_eff = dyn_ok ? dyn_code : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr1_rtt    <= '0;
            mr2_rtt_wr <= '0;
            cfg_err    <= 1'b0;
            term_on    <= 1'b0;
            lead_q     <= '0;
        end else begin
            mr1_rtt    <= nom_eff;
            mr2_rtt_wr <= dyn_eff;
            cfg_err    <= type_bad | nom_bad | dyn_bad;
            term_on    <= nom_ok | dyn_ok;
            lead_q     <= lead_cyc;
        end
    end
endmodule

// File: rtl/term_cnt.sv
module term_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (dec) cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/term_fsm.sv
module term_fsm
    import term_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int LEAD_W = 3,
    parameter int CW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              term_on,
    input  logic [LEAD_W-1:0] lead,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              sr_req,
    input  logic              cnt_zero,
    output logic              cnt_ld,
    output logic [CW-1:0]     cnt_val,
    output logic              cnt_dec,
    output logic              odt,
    output logic              wdata_en,
    output logic              wr_start
);
    localparam logic [CW-1:0] BURST_LAST = CW'(BEATS - 1);

    odt_state_t state, nxt;
    logic       burst_ld, first_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            state   <= nxt;
            first_q <= burst_ld;
        end
    end

    // next state and counter control
    always_comb begin
        nxt      = state;
        cnt_ld   = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        burst_ld = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sr_req) begin
                    nxt = ST_SREF;
                end else if (wr_req) begin
                    cnt_ld = 1'b1;
                    if (term_on && lead != '0) begin
                        nxt     = ST_LEAD;
                        cnt_val = CW'(lead) - CW'(1);
                    end else begin
                        nxt      = ST_BURST;
                        cnt_val  = BURST_LAST;
                        burst_ld = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (cnt_zero) begin
                    nxt      = ST_BURST;
                    cnt_ld   = 1'b1;
                    cnt_val  = BURST_LAST;
                    burst_ld = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_BURST: begin
                if (cnt_zero) begin
                    if (wr_req) begin
                        cnt_ld   = 1'b1;
                        cnt_val  = BURST_LAST;
                        burst_ld = 1'b1;
                    end else if (term_on) begin
                        nxt     = ST_HOLD;
                        cnt_ld  = 1'b1;
                        cnt_val = BURST_LAST;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (sr_req) begin
                    nxt = ST_SREF;
                end else if (wr_req) begin
                    nxt      = ST_BURST;
                    cnt_ld   = 1'b1;
                    cnt_val  = BURST_LAST;
                    burst_ld = 1'b1;
                end else if (rd_req || cnt_zero) begin
                    nxt = ST_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_SREF: begin
                if (!sr_req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        odt      = 1'b0;
        wdata_en = 1'b0;
        unique case (state)
            ST_LEAD:  odt = term_on;
            ST_BURST: begin
                odt      = term_on;
                wdata_en = 1'b1;
            end
            ST_HOLD:  odt = term_on;
            default:  odt = 1'b0;
        endcase
        wr_start = first_q;
    end
endmodule

// File: rtl/term_ctrl.sv
module term_ctrl
    import term_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int LEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TYPE_W-1:0] mem_type,
    input  logic [NOM_W-1:0]  nom_code,
    input  logic [DYN_W-1:0]  dyn_code,
    input  logic [LEAD_W-1:0] lead_cyc,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              sr_req,
    output logic              odt,
    output logic              wdata_en,
    output logic              wr_start,
    output logic [NOM_W-1:0]  mr1_rtt,
    output logic [DYN_W-1:0]  mr2_rtt_wr,
    output logic              cfg_err
);
    localparam int BW = $clog2(BEATS + 1);
    localparam int CW = (BW > LEAD_W) ? BW : LEAD_W;

    logic              term_on;
    logic [LEAD_W-1:0] dec_lead;
    logic              cnt_ld, cnt_dec, cnt_zero;
    logic [CW-1:0]     cnt_val, cnt_q;

    term_decode #(.LEAD_W(LEAD_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_type   (mem_type),
        .nom_code   (nom_code),
        .dyn_code   (dyn_code),
        .lead_cyc   (lead_cyc),
        .mr1_rtt    (mr1_rtt),
        .mr2_rtt_wr (mr2_rtt_wr),
        .cfg_err    (cfg_err),
        .term_on    (term_on),
        .lead_q     (dec_lead)
    );

    term_cnt #(.W(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (cnt_val),
        .dec    (cnt_dec),
        .cnt    (cnt_q),
        .zero   (cnt_zero)
    );

    term_fsm #(.BEATS(BEATS), .LEAD_W(LEAD_W), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .term_on  (term_on),
        .lead     (dec_lead),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .sr_req   (sr_req),
        .cnt_zero (cnt_zero),
        .cnt_ld   (cnt_ld),
        .cnt_val  (cnt_val),
        .cnt_dec  (cnt_dec),
        .odt      (odt),
        .wdata_en (wdata_en),
        .wr_start (wr_start)
    );
endmodule

// File: rtl/term_chk.sv
module term_chk
    import term_pkg::*;
#(
    parameter int LEAD_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TYPE_W-1:0] mem_type,
    input logic [NOM_W-1:0]  nom_code,
    input logic              odt,
    input logic              wdata_en,
    input logic              wr_start,
    input logic [NOM_W-1:0]  mr1_rtt,
    input logic [DYN_W-1:0]  mr2_rtt_wr,
    input logic              cfg_err,
    input logic [LEAD_W-1:0] lead_q
);
    logic pv;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    // R1
    lp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(mem_type) == MT_LP) |-> (!odt && mr1_rtt == '0 && mr2_rtt_wr == '0));

    // R2
    ddr2_no_dyn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(mem_type) == MT_D2) |-> (mr2_rtt_wr == '0));

    // R4
    rsv_nom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(mem_type) == MT_D3 && $past(nom_code) > D3_NOM_MAX) |-> (cfg_err && mr1_rtt == '0));

    // R7
    start_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> wdata_en);

    // R5
    lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $rose(odt) && !$past(wdata_en) && lead_q != '0) |-> !wdata_en);
endmodule

bind term_ctrl term_chk #(.LEAD_W(LEAD_W)) u_term_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_type   (mem_type),
    .nom_code   (nom_code),
    .odt        (odt),
    .wdata_en   (wdata_en),
    .wr_start   (wr_start),
    .mr1_rtt    (mr1_rtt),
    .mr2_rtt_wr (mr2_rtt_wr),
    .cfg_err    (cfg_err),
    .lead_q     (dec_lead)
);

// File: tb/test_term_ctrl.sv
module test_term_ctrl;
    localparam int BEATS  = 4;
    localparam int LEAD_W = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [1:0]        mem_type;
    logic [2:0]        nom_code;
    logic [1:0]        dyn_code;
    logic [LEAD_W-1:0] lead_cyc;
    logic              wr_req, rd_req, sr_req;
    logic              odt, wdata_en, wr_start, cfg_err;
    logic [2:0]        mr1_rtt;
    logic [1:0]        mr2_rtt_wr;

    term_ctrl #(.BEATS(BEATS), .LEAD_W(LEAD_W)) i_term_ctrl (
        .clk(clk), .rst_n(rst_n), .mem_type(mem_type), .nom_code(nom_code),
        .dyn_code(dyn_code), .lead_cyc(lead_cyc), .wr_req(wr_req), .rd_req(rd_req),
        .sr_req(sr_req), .odt(odt), .wdata_en(wdata_en), .wr_start(wr_start),
        .mr1_rtt(mr1_rtt), .mr2_rtt_wr(mr2_rtt_wr), .cfg_err(cfg_err)
    );

    int    errs = 0;
    int    checks = 0;
    string cur_req = "R12";
    bit    finished = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // expected decode from the requirement tables
    task automatic exp_decode(input int t, input int n, input int d,
                              output int f1, output int f2, output int er, output int on);
        int lim;
        lim = (t == 2) ? 3 : ((t == 3) ? 5 : 0);
        er  = (t == 0 || n > lim || (t == 3 && d > 2)) ? 1 : 0;
        f1  = (t >= 2 && n <= lim) ? n : 0;
        f2  = (t == 3 && d <= 2) ? d : 0;
        on  = (f1 != 0 || f2 != 0) ? 1 : 0;
    endtask

    // behavioural reference model
    int m_lead_left, m_beat_left, m_hold_left;
    int m_mr1, m_mr2, m_err, m_on, m_lead;
    bit m_sref, m_first;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lead_left = 0; m_beat_left = 0; m_hold_left = 0;
            m_mr1 = 0; m_mr2 = 0; m_err = 0; m_on = 0; m_lead = 0;
            m_sref = 1'b0; m_first = 1'b0;
        end else begin
            m_first = 1'b0;
            if (m_sref) begin
                if (!sr_req) m_sref = 1'b0;
            end else if (m_lead_left > 0) begin
                m_lead_left--;
                if (m_lead_left == 0) begin m_beat_left = BEATS; m_first = 1'b1; end
            end else if (m_beat_left > 0) begin
                m_beat_left--;
                if (m_beat_left == 0) begin
                    if (wr_req) begin m_beat_left = BEATS; m_first = 1'b1; end
                    else if (m_on != 0) m_hold_left = BEATS;
                end
            end else if (m_hold_left > 0) begin
                if (sr_req) begin m_hold_left = 0; m_sref = 1'b1; end
                else if (wr_req) begin m_hold_left = 0; m_beat_left = BEATS; m_first = 1'b1; end
                else if (rd_req) m_hold_left = 0;
                else m_hold_left--;
            end else begin
                if (sr_req) m_sref = 1'b1;
                else if (wr_req) begin
                    if (m_on != 0 && m_lead > 0) m_lead_left = m_lead;
                    else begin m_beat_left = BEATS; m_first = 1'b1; end
                end
            end
            exp_decode(int'(mem_type), int'(nom_code), int'(dyn_code), m_mr1, m_mr2, m_err, m_on);
            m_lead = int'(lead_cyc);
        end
    end

    // cycle-by-cycle comparison, away from the edge
    always @(posedge clk) begin
        if (rst_n) begin
            #2;
            chk(cur_req, "odt", int'(odt),
                (m_on != 0 && (m_lead_left > 0 || m_beat_left > 0 || m_hold_left > 0)) ? 1 : 0);
            chk(cur_req, "wdata_en", int'(wdata_en), (m_beat_left > 0) ? 1 : 0);
            chk(cur_req, "wr_start", int'(wr_start), int'(m_first));
            chk(cur_req, "mr1_rtt", int'(mr1_rtt), m_mr1);
            chk(cur_req, "mr2_rtt_wr", int'(mr2_rtt_wr), m_mr2);
            chk(cur_req, "cfg_err", int'(cfg_err), m_err);
        end
    end

    task automatic setcfg(int t, int n, int d, int l);
        @(negedge clk);
        mem_type = 2'(t); nom_code = 3'(n); dyn_code = 2'(d); lead_cyc = LEAD_W'(l);
        repeat (2) @(negedge clk);
    endtask

    // issue nb back-to-back bursts, measure timing seen at the pins
    task automatic do_write(int nb, output int odt_at, output int wd_at,
                            output int beats, output int hold);
        int c = 0, starts = 0, last_wd = -1, guard = 0;
        odt_at = -1; wd_at = -1; beats = 0; hold = -1;
        @(negedge clk);
        wr_req = 1'b1;
        while (guard < 200) begin
            @(negedge clk);
            c++; guard++;
            if (odt && odt_at < 0) odt_at = c;
            if (wdata_en) begin
                if (wd_at < 0) wd_at = c;
                beats++;
                last_wd = c;
            end
            if (wr_start) begin
                starts++;
                if (starts == nb) wr_req = 1'b0;
            end
            if (starts == nb && !wdata_en && last_wd > 0) begin
                if (!odt) begin
                    hold = c - last_wd - 1;
                    break;
                end
            end
        end
        repeat (2) @(negedge clk);
    endtask

    int oa, wa, bt, hd;
    int e1, e2, e3, e4;

    initial begin
        rst_n = 1'b0; mem_type = 2'd0; nom_code = 3'd0; dyn_code = 2'd0; lead_cyc = '0;
        wr_req = 1'b0; rd_req = 1'b0; sr_req = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "reset odt", int'(odt), 0);
        chk("R12", "reset wdata_en", int'(wdata_en), 0);
        chk("R12", "reset wr_start", int'(wr_start), 0);
        chk("R12", "reset fields", int'(mr1_rtt) + int'(mr2_rtt_wr) + int'(cfg_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 / R1 / R2 / R3 full code sweep
        for (int t = 0; t < 4; t++) begin
            for (int n = 0; n < 8; n++) begin
                for (int d = 0; d < 4; d++) begin
                    cur_req = (t <= 1) ? "R1" : ((t == 2) ? "R2" : "R3");
                    setcfg(t, n, d, 0);
                    exp_decode(t, n, d, e1, e2, e3, e4);
                    chk(cur_req, "sweep mr1_rtt", int'(mr1_rtt), e1);
                    chk(cur_req, "sweep mr2_rtt_wr", int'(mr2_rtt_wr), e2);
                    chk("R4", "sweep cfg_err", int'(cfg_err), e3);
                end
            end
        end

        // R1 LPDDR: no termination at the pin
        cur_req = "R1";
        setcfg(1, 2, 1, 3);
        do_write(1, oa, wa, bt, hd);
        chk("R1", "lpddr odt never high", oa, -1);
        chk("R1", "lpddr write start", wa, 1);

        // R2 DDR2, dynamic ignored, lead 2
        cur_req = "R2";
        setcfg(2, 2, 2, 2);
        chk("R2", "ddr2 mr2 ignored", int'(mr2_rtt_wr), 0);
        do_write(1, oa, wa, bt, hd);
        chk("R2", "ddr2 lead", wa - oa, 2);

        // R5 lead sweep on DDR3
        cur_req = "R5";
        for (int l = 1; l < 8; l++) begin
            setcfg(3, 1, 0, l);
            do_write(1, oa, wa, bt, hd);
            chk("R5", "odt rise latency", oa, 1);
            chk("R5", "lead cycles", wa - oa, l);
            cur_req = "R8";
            chk("R8", "hold cycles", hd, BEATS);
            cur_req = "R5";
        end

        // R6 zero lead
        cur_req = "R6";
        setcfg(3, 2, 1, 0);
        do_write(1, oa, wa, bt, hd);
        chk("R6", "odt rise", oa, 1);
        chk("R6", "data with odt", wa, 1);

        // R7 burst length
        cur_req = "R7";
        setcfg(3, 3, 0, 1);
        do_write(1, oa, wa, bt, hd);
        chk("R7", "beats in one burst", bt, BEATS);

        // R9 back-to-back bursts
        cur_req = "R9";
        setcfg(3, 1, 2, 3);
        do_write(2, oa, wa, bt, hd);
        chk("R9", "two bursts contiguous", bt, 2 * BEATS);

        // R9 write during hold: no new lead
        @(negedge clk); wr_req = 1'b1;
        while (!wr_start) @(negedge clk);
        wr_req = 1'b0;
        while (wdata_en) @(negedge clk);
        @(negedge clk);
        wr_req = 1'b1;
        @(negedge clk);
        chk("R9", "write in hold starts at once", int'(wdata_en), 1);
        chk("R9", "odt kept high", int'(odt), 1);
        wr_req = 1'b0;
        repeat (3 * BEATS) @(negedge clk);

        // R10 read during hold drops odt
        cur_req = "R10";
        @(negedge clk); wr_req = 1'b1;
        while (!wr_start) @(negedge clk);
        wr_req = 1'b0;
        while (wdata_en) @(negedge clk);
        chk("R10", "odt in hold", int'(odt), 1);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R10", "odt after read", int'(odt), 0);
        repeat (2) @(negedge clk);

        // R10 self-refresh during hold, writes ignored
        @(negedge clk); wr_req = 1'b1;
        while (!wr_start) @(negedge clk);
        wr_req = 1'b0;
        while (wdata_en) @(negedge clk);
        sr_req = 1'b1; wr_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10", "odt in self-refresh", int'(odt), 0);
            chk("R10", "no data in self-refresh", int'(wdata_en), 0);
        end
        wr_req = 1'b0;
        @(negedge clk);
        sr_req = 1'b0;
        repeat (3) @(negedge clk);

        // R11 no effective termination: reserved nominal, illegal dynamic
        cur_req = "R11";
        setcfg(3, 6, 3, 4);
        do_write(1, oa, wa, bt, hd);
        chk("R11", "odt stays low", oa, -1);
        chk("R11", "no stall", wa, 1);
        setcfg(3, 0, 0, 5);
        do_write(1, oa, wa, bt, hd);
        chk("R11", "off odt stays low", oa, -1);
        chk("R11", "off no stall", wa, 1);

        // R12 dynamic only: termination only around writes
        cur_req = "R12";
        setcfg(3, 0, 1, 2);
        chk("R12", "dyn-only mr2", int'(mr2_rtt_wr), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rd_req = ~rd_req;
            chk("R12", "odt idle with reads", int'(odt), 0);
        end
        rd_req = 1'b0;
        do_write(1, oa, wa, bt, hd);
        chk("R12", "dyn-only write odt", oa, 1);
        chk("R12", "dyn-only odt low after", int'(odt), 0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule